// File: doc/BRIEF.md
# Set/Reset Pulse Level Decoder with Link Watchdog

This block rebuilds a logic level on the receive side of an isolation link. The link does not carry the level itself. It carries two kinds of single-cycle pulses: a set pulse, which means the level is now high, and a clear pulse, which means it is now low. A bistable register holds the last level it was told. The transmitter repeats the current level at a fixed refresh interval even when the level does not change, so a healthy link delivers a pulse at least once per refresh period.

A watchdog counts clock cycles since the last pulse of either kind. It allows a window several refresh periods long, four by default. If no pulse arrives in that window, the block treats the far side as unpowered or broken. It then forces the data output to the safe low level and drops the link-valid output. The next pulse of either kind restores link-valid and loads the level that pulse encodes. The pulse inputs are assumed to be already synchronous to `clk_i`.

Top module: `pulse_level_decoder`

## Requirements
- R1: A cycle with `set_i`=1 and `clr_i`=0 makes `data_o` 1 after the next rising clock edge.
- R2: A cycle with `clr_i`=1 and `set_i`=0 makes `data_o` 0 after the next rising clock edge.
- R3: In cycles with neither pulse, `data_o` keeps its value, unless the watchdog expires at that edge.
- R4: Call the clock edge that samples a pulse edge P. If the TIMEOUT_CYC edges after P (TIMEOUT_CYC = REFRESH_CYC * TIMEOUT_MULT, default 64) all see no pulse, then after edge P+TIMEOUT_CYC both `data_o` and `link_ok_o` are 0.
- R5: A pulse of either kind restarts the watchdog window. A pulse sampled on edge P+TIMEOUT_CYC therefore keeps `link_ok_o` at 1 with no gap.
- R6: With `link_ok_o`=0, the next pulse sets `link_ok_o` to 1 after that edge, and `data_o` takes the level the pulse encodes (1 for set, 0 for clear).
- R7: A cycle with both `set_i` and `clr_i` at 1 leaves `data_o` unchanged. It still restarts the watchdog and sets `link_ok_o` to 1.
- R8: While `rst_ni` is 0, `data_o` and `link_ok_o` are 0. After release, both stay 0 until the first pulse.
- R9: Whenever `link_ok_o` is 0, `data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive-side clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| set_i | input | 1 | Single-cycle pulse meaning the level is high |
| clr_i | input | 1 | Single-cycle pulse meaning the level is low |
| data_o | output | 1 | Reconstructed level; forced low when the link is invalid |
| link_ok_o | output | 1 | High while pulses arrive within the watchdog window |

## Verification
Two events can land on the same clock edge: the watchdog expiring, and a pulse arriving on exactly the last cycle of the window. In that case the pulse must win. The bench provokes this by idling for exactly TIMEOUT_CYC-1 cycles and then pulsing, and expects `link_ok_o` to stay 1. It also idles one cycle longer and expects the forced low. Set and clear landing on the same edge is exercised with the output both high and low, and again just after a timeout, where it must restore link-valid while the data stays low.

// File: rtl/pdec_pkg.sv
package pdec_pkg;
  typedef enum logic [1:0] {
    PK_NONE = 2'b00,
    PK_SET  = 2'b01,
    PK_CLR  = 2'b10,
    PK_BOTH = 2'b11
  } pulse_kind_e;
endpackage

// File: rtl/pdec_classify.sv
module pdec_classify
  import pdec_pkg::*;
(
  input  logic        set_i,
  input  logic        clr_i,
  output pulse_kind_e kind_o,
  output logic        any_o
);
  always_comb begin
    unique case ({clr_i, set_i})
      2'b01:   kind_o = PK_SET;
      2'b10:   kind_o = PK_CLR;
      2'b11:   kind_o = PK_BOTH;
      default: kind_o = PK_NONE;
    endcase
  end
  assign any_o = set_i | clr_i;
endmodule

// File: rtl/pdec_watchdog.sv
module pdec_watchdog #(
  parameter int unsigned TIMEOUT_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);
  localparam logic [CW-1:0] LAST  = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;

  // Saturated at reset so no strobe fires before the first pulse
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= LIMIT;
    else if (pulse_i)       cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = ~pulse_i & (cnt_q == LAST);
endmodule

// File: rtl/pdec_level.sv
module pdec_level
  import pdec_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  pulse_kind_e kind_i,
  input  logic        expire_i,
  output logic        level_o,
  output logic        valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      level_o <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      unique case (kind_i)
        PK_SET:  begin level_o <= 1'b1; valid_o <= 1'b1; end
        PK_CLR:  begin level_o <= 1'b0; valid_o <= 1'b1; end
        PK_BOTH: valid_o <= 1'b1;
        default: if (expire_i) begin
                   level_o <= 1'b0;
                   valid_o <= 1'b0;
                 end
      endcase
    end
  end
endmodule

// File: rtl/pulse_level_decoder.sv
module pulse_level_decoder #(
  parameter int unsigned REFRESH_CYC  = 16,
  parameter int unsigned TIMEOUT_MULT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic data_o,
  output logic link_ok_o
);
  import pdec_pkg::*;

  localparam int unsigned TIMEOUT_CYC = REFRESH_CYC * TIMEOUT_MULT;

  pulse_kind_e kind;
  logic        any_pulse;
  logic        expire;

  pdec_classify u_cls (
    .set_i  (set_i),
    .clr_i  (clr_i),
    .kind_o (kind),
    .any_o  (any_pulse)
  );

  pdec_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pulse_i  (any_pulse),
    .expire_o (expire)
  );

  pdec_level u_lvl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kind_i   (kind),
    .expire_i (expire),
    .level_o  (data_o),
    .valid_o  (link_ok_o)
  );
endmodule

// File: rtl/pdec_checker.sv
module pdec_checker #(
  parameter int unsigned TIMEOUT_CYC = 64
) (
  input logic clk_i,
  input logic rst_ni,
  input logic set_i,
  input logic clr_i,
  input logic data_o,
  input logic link_ok_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);
  localparam logic [CW-1:0] LAST  = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] idle_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              idle_q <= LIMIT;
    else if (set_i || clr_i)  idle_q <= '0;
    else if (idle_q != LIMIT) idle_q <= idle_q + 1'b1;
  end

  AST_SET_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clr_i) |=> data_o); // R1
  AST_CLR_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !data_o); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && !clr_i && idle_q < LAST) |=> $stable(data_o)); // R3
  AST_TIMEOUT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_q == LIMIT) |-> !link_ok_o); // R4
  AST_WINDOW_ALIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_q != LIMIT) |-> link_ok_o); // R5
  AST_PULSE_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i || clr_i) |=> link_ok_o); // R6
  AST_BOTH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && clr_i) |=> $stable(data_o)); // R7
  AST_INVALID_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_ok_o |-> !data_o); // R9
endmodule

bind pulse_level_decoder pdec_checker #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .set_i     (set_i),
  .clr_i     (clr_i),
  .data_o    (data_o),
  .link_ok_o (link_ok_o)
);

// File: tb/sim_pulse_level_decoder.sv
module sim_pulse_level_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int T = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set_p = 1'b0;
  logic clr_p = 1'b0;
  logic data, link;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_level_decoder u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .set_i     (set_p),
    .clr_i     (clr_p),
    .data_o    (data),
    .link_ok_o (link)
  );

  typedef struct {
    logic  d;
    logic  l;
    string tag;
  } exp_t;
  exp_t q[$];

  // Reference state derived from the requirements
  bit m_d = 1'b0;
  bit m_l = 1'b0;
  int m_idle = T;

  task automatic chk(logic ad, logic al, logic ed, logic el, string tag);
    checks++;
    if (ad !== ed || al !== el) begin
      errors++;
      $display("FAIL %s: data=%b link=%b expected data=%b link=%b", tag, ad, al, ed, el);
    end
  endtask

  task automatic step(bit s, bit c, string tag);
    exp_t e;
    @(negedge clk);
    set_p = s;
    clr_p = c;
    if (s || c) begin
      m_idle = 0;
      m_l = 1'b1;
      if (s && !c) m_d = 1'b1;
      if (c && !s) m_d = 1'b0;
    end else if (m_idle < T) begin
      m_idle++;
      if (m_idle == T) begin
        m_d = 1'b0;
        m_l = 1'b0;
      end
    end
    e.d = m_d;
    e.l = m_l;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, tag);
  endtask

  // Monitor: one expected item per clock edge
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk(data, link, e.d, e.l, e.tag);
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: data=%b link=%b expected run to complete", data, link);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(data, link, 1'b0, 1'b0, "R8 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    idle(10, "R8 idle after reset");
    step(1, 0, "R1 set");
    idle(20, "R3 hold high");
    step(0, 1, "R2 clear");
    idle(12, "R3 hold low");
    step(1, 1, "R7 both while low");
    step(1, 0, "R1 set again");
    step(1, 1, "R7 both while high");
    idle(5, "R3 hold after both");
    for (int k = 0; k < 6; k++) begin
      idle(15, "R5 refresh gap");
      step(1, 0, "R5 refresh set");
    end
    idle(T - 1, "R3 near window end");
    step(0, 1, "R5 pulse on last window cycle");
    idle(T - 1, "R3 before expiry");
    step(0, 0, "R4 expiry edge");
    idle(6, "R9 invalid stays low");
    step(0, 1, "R6 clear restores link");
    idle(T, "R4 second expiry");
    step(1, 0, "R6 set restores link high");
    idle(3, "R3 hold after restore");
    idle(T, "R4 third expiry");
    step(1, 1, "R7 both after expiry");
    idle(4, "R9 hold low valid");
    step(0, 0, "R3 final");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule